// File: doc/BRIEF.md
# Carry-Linked Shift and Rotate Unit

This block performs the shift and rotate group of a 16-bit execution datapath on either a byte or a word operand. A caller presents an operand, a three-bit operation code, a width select, a count source and the present flag values, then pulses `start_i`. The unit moves the operand one bit position per clock for as many clocks as the count asks. It then presents the result together with updated carry, overflow, zero, sign and parity flags, and marks their arrival with a single-cycle `done_o` pulse.

Seven distinct operations are covered: a left shift that feeds zeros in, a right shift that feeds zeros in, a right shift that copies the sign, plain rotates in both directions, and rotates in both directions that treat the carry flag as one more bit of the ring. The count is either a fixed 1 or an 8-bit value from a count register. Counts larger than the operand width are honoured literally: they behave as that many single-bit steps.

Top module: `shrot_unit`

## Requirements
- R1: Operation codes on `op_i` are 0 rotate-left, 1 rotate-right, 2 rotate-left-through-carry, 3 rotate-right-through-carry, 4 shift-left, 5 logical shift-right, 6 shift-left (same as 4), 7 arithmetic shift-right. A left shift feeds 0 into bit 0, and the carry output is the last bit moved out of the most significant position.
- R2: A logical right shift feeds 0 into the most significant bit. An arithmetic right shift keeps the sign bit in place. For both, the carry output is the last bit moved out of bit 0.
- R3: Plain rotates form a ring exactly as wide as the operand, and the carry output is a copy of the last bit that wrapped around.
- R4: Rotates through carry form a ring one bit wider than the operand, with the incoming carry as the extra bit, so a count of width+1 returns both the operand and the carry unchanged.
- R5: With `word_i`=0 only bits 7:0 take part, bit 7 is the sign bit, and result bits 15:8 equal operand bits 15:8. With `word_i`=1 all 16 bits take part.
- R6: With `use_cnt_i`=0 the count is 1, and with `use_cnt_i`=1 it is `cnt_i` (0 to 255). Any count gives the same outcome as repeating the single-bit operation that many times, so a word shift-left by 16 yields 0.
- R7: A count of 0 returns the operand unchanged and copies all five incoming flags to the outputs.
- R8: For a nonzero count, the overflow output is 1 exactly when the sign bit of the result differs from the sign bit of the operand.
- R9: After a shift with a nonzero count, zero is 1 when the operand-width result is 0, sign equals the result's sign bit, and parity is 1 when result bits 7:0 hold an even number of ones.
- R10: After a rotate (either kind) with a nonzero count, the zero, sign and parity outputs equal the incoming values.
- R11: After reset `busy_o`, `done_o`, the result and all flags are 0. For a count N of 1 or more, `busy_o` is high for exactly N clocks, starting with the clock after the start edge. `done_o` is high for one clock as `busy_o` falls, or in the clock after the start edge when N is 0. Result and flags then hold until the next accepted start.
- R12: A `start_i` pulse while `busy_o` is high is ignored, and the operation in flight completes with its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken when the unit is idle |
| op_i | input | 3 | Operation code |
| word_i | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| use_cnt_i | input | 1 | 1 = count from `cnt_i`, 0 = count of 1 |
| cnt_i | input | 8 | Count register value |
| opnd_i | input | 16 | Operand |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| zf_i | input | 1 | Incoming zero flag |
| sf_i | input | 1 | Incoming sign flag |
| pf_i | input | 1 | Incoming parity flag |
| busy_o | output | 1 | High while bit steps remain |
| done_o | output | 1 | One-cycle pulse when result and flags are valid |
| res_o | output | 16 | Result |
| cf_o | output | 1 | Carry flag out |
| of_o | output | 1 | Overflow flag out |
| zf_o | output | 1 | Zero flag out |
| sf_o | output | 1 | Sign flag out |
| pf_o | output | 1 | Parity flag out |

## Verification
On every cycle, the assertions hold the handshake shape: busy and done are never high together, and busy always falls into a done. They also check that the captured operation stays frozen while busy, that the upper byte survives byte-mode steps, and that overflow follows the sign change. They further check that rotates keep zero, sign and parity, that shift results agree with the zero flag, and that a zero count returns the operand and carry. The actual bit movement can only be shown by the bench's scenarios, which compare against a separately written model. This covers fill values, the extra carry bit of the wider ring, counts beyond the width, wrap-back after width+1 steps, parity over the low byte and the exact number of busy cycles.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAL = 3'd6,
        OP_SAR = 3'd7
    } shrot_op_e;

    // Codes 0..3 are the rotate family, 4..7 the shift family.
    function automatic logic op_is_rotate(input shrot_op_e op);
        logic [2:0] raw;
        raw = op;
        return ~raw[2];
    endfunction

endpackage

// File: rtl/shrot_lane.sv
// One-bit step on a lane of LW bits.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [LW-1:0] val_i,
    input  logic          cf_i,
    input  shrot_op_e     op_i,
    output logic [LW-1:0] val_o,
    output logic          cf_o
);

    always_comb begin
        unique case (op_i)
            OP_SHL, OP_SAL: begin
                cf_o  = val_i[LW-1];
                val_o = {val_i[LW-2:0], 1'b0};
            end
            OP_SHR: begin
                cf_o  = val_i[0];
                val_o = {1'b0, val_i[LW-1:1]};
            end
            OP_SAR: begin
                cf_o  = val_i[0];
                val_o = {val_i[LW-1], val_i[LW-1:1]};
            end
            OP_ROL: begin
                cf_o  = val_i[LW-1];
                val_o = {val_i[LW-2:0], val_i[LW-1]};
            end
            OP_ROR: begin
                cf_o  = val_i[0];
                val_o = {val_i[0], val_i[LW-1:1]};
            end
            OP_RCL: begin
                cf_o  = val_i[LW-1];
                val_o = {val_i[LW-2:0], cf_i};
            end
            OP_RCR: begin
                cf_o  = val_i[0];
                val_o = {cf_i, val_i[LW-1:1]};
            end
            default: begin
                cf_o  = cf_i;
                val_o = val_i;
            end
        endcase
    end

endmodule

// File: rtl/shrot_step.sv
// Width-selecting one-bit step: full lane for words, low half lane for bytes.
module shrot_step
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         cf_i,
    input  shrot_op_e    op_i,
    input  logic         word_i,
    output logic [W-1:0] val_o,
    output logic         cf_o
);

    localparam int HW = W / 2;

    logic [W-1:0]  full_val;
    logic          full_cf;
    logic [HW-1:0] half_val;
    logic          half_cf;

    shrot_lane #(.LW(W)) i_full_lane (
        .val_i (val_i),
        .cf_i  (cf_i),
        .op_i  (op_i),
        .val_o (full_val),
        .cf_o  (full_cf)
    );

    shrot_lane #(.LW(HW)) i_half_lane (
        .val_i (val_i[HW-1:0]),
        .cf_i  (cf_i),
        .op_i  (op_i),
        .val_o (half_val),
        .cf_o  (half_cf)
    );

    always_comb begin
        if (word_i) begin
            val_o = full_val;
            cf_o  = full_cf;
        end else begin
            val_o = {val_i[W-1:HW], half_val};
            cf_o  = half_cf;
        end
    end

endmodule

// File: rtl/shrot_flags.sv
// Status flag evaluation for a finished nonzero-count operation.
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         word_i,
    input  shrot_op_e    op_i,
    input  logic         orig_msb_i,
    input  logic         zf_i,
    input  logic         sf_i,
    input  logic         pf_i,
    output logic         of_o,
    output logic         zf_o,
    output logic         sf_o,
    output logic         pf_o
);

    localparam int HW = W / 2;

    logic msb;
    logic is_zero;

    always_comb begin
        msb     = word_i ? val_i[W-1] : val_i[HW-1];
        is_zero = word_i ? (val_i == '0) : (val_i[HW-1:0] == '0);
        of_o    = msb ^ orig_msb_i;
        if (op_is_rotate(op_i)) begin
            zf_o = zf_i;
            sf_o = sf_i;
            pf_o = pf_i;
        end else begin
            zf_o = is_zero;
            sf_o = msb;
            pf_o = ~^val_i[HW-1:0];
        end
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic             word_i,
    input  logic             use_cnt_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [W-1:0]     opnd_i,
    input  logic             cf_i,
    input  logic             of_i,
    input  logic             zf_i,
    input  logic             sf_i,
    input  logic             pf_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W-1:0]     res_o,
    output logic             cf_o,
    output logic             of_o,
    output logic             zf_o,
    output logic             sf_o,
    output logic             pf_o
);

    localparam int HW = W / 2;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] rem;
        logic [W-1:0]     val;
        logic             cf;
        logic             of;
        logic             zf;
        logic             sf;
        logic             pf;
        shrot_op_e        op;
        logic             word;
        logic             orig_msb;
        logic             zero_cnt;
        logic             in_zf;
        logic             in_sf;
        logic             in_pf;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]     step_val;
    logic             step_cf;
    logic             fl_of, fl_zf, fl_sf, fl_pf;
    logic [CNT_W-1:0] req_cnt;

    shrot_step #(.W(W)) i_step (
        .val_i  (state_q.val),
        .cf_i   (state_q.cf),
        .op_i   (state_q.op),
        .word_i (state_q.word),
        .val_o  (step_val),
        .cf_o   (step_cf)
    );

    shrot_flags #(.W(W)) i_flags (
        .val_i      (step_val),
        .word_i     (state_q.word),
        .op_i       (state_q.op),
        .orig_msb_i (state_q.orig_msb),
        .zf_i       (state_q.in_zf),
        .sf_i       (state_q.in_sf),
        .pf_i       (state_q.in_pf),
        .of_o       (fl_of),
        .zf_o       (fl_zf),
        .sf_o       (fl_sf),
        .pf_o       (fl_pf)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        req_cnt      = use_cnt_i ? cnt_i : CNT_W'(1);
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.val      = opnd_i;
                state_d.cf       = cf_i;
                state_d.op       = shrot_op_e'(op_i);
                state_d.word     = word_i;
                state_d.orig_msb = word_i ? opnd_i[W-1] : opnd_i[HW-1];
                state_d.in_zf    = zf_i;
                state_d.in_sf    = sf_i;
                state_d.in_pf    = pf_i;
                state_d.rem      = req_cnt;
                state_d.zero_cnt = (req_cnt == '0);
                if (req_cnt == '0) begin
                    state_d.done = 1'b1;
                    state_d.of   = of_i;
                    state_d.zf   = zf_i;
                    state_d.sf   = sf_i;
                    state_d.pf   = pf_i;
                end else begin
                    state_d.busy = 1'b1;
                end
            end
        end else begin
            state_d.val = step_val;
            state_d.cf  = step_cf;
            state_d.rem = state_q.rem - CNT_W'(1);
            if (state_q.rem == CNT_W'(1)) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
                state_d.of   = fl_of;
                state_d.zf   = fl_zf;
                state_d.sf   = fl_sf;
                state_d.pf   = fl_pf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy_o = state_q.busy;
    assign done_o = state_q.done;
    assign res_o  = state_q.val;
    assign cf_o   = state_q.cf;
    assign of_o   = state_q.of;
    assign zf_o   = state_q.zf;
    assign sf_o   = state_q.sf;
    assign pf_o   = state_q.pf;

    // Handshake shape
    assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    assert_fall_gives_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // Captured request must not move while stepping
    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(state_q.op) && $stable(state_q.word) && $stable(state_q.orig_msb)));

    // Byte steps leave the upper half alone
    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !state_q.word) |=> (res_o[W-1:HW] == $past(res_o[W-1:HW])));

    // Overflow follows the sign change
    assert_of_sign_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !state_q.zero_cnt) |->
            (of_o == ((state_q.word ? res_o[W-1] : res_o[HW-1]) ^ state_q.orig_msb)));

    // Rotates keep the result-derived flags
    assert_rot_flags_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_is_rotate(state_q.op)) |->
            (zf_o == state_q.in_zf && sf_o == state_q.in_sf && pf_o == state_q.in_pf));

    // Shift zero flag agrees with the result
    assert_shift_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !state_q.zero_cnt && !op_is_rotate(state_q.op)) |->
            (zf_o == (state_q.word ? (res_o == '0) : (res_o[HW-1:0] == '0))));

    // Zero count passes operand and carry through
    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && state_q.zero_cnt) |-> (res_o == $past(opnd_i) && cf_o == $past(cf_i)));

endmodule

// File: tb/test_shrot_unit.sv
module test_shrot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        word_i = 1'b0;
    logic        use_cnt_i = 1'b0;
    logic [7:0]  cnt_i = '0;
    logic [15:0] opnd_i = '0;
    logic        cf_i = 1'b0, of_i = 1'b0, zf_i = 1'b0, sf_i = 1'b0, pf_i = 1'b0;
    logic        busy_o, done_o, cf_o, of_o, zf_o, sf_o, pf_o;
    logic [15:0] res_o;

    int checks = 0;
    int failures = 0;
    int busy_run = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] res;
        logic        cf, of, zf, sf, pf;
        int          cycles;
        string       tag;
        string       ftag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    shrot_unit i_shrot_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .word_i(word_i),
        .use_cnt_i(use_cnt_i), .cnt_i(cnt_i), .opnd_i(opnd_i), .cf_i(cf_i),
        .of_i(of_i), .zf_i(zf_i), .sf_i(sf_i), .pf_i(pf_i),
        .busy_o(busy_o), .done_o(done_o), .res_o(res_o), .cf_o(cf_o),
        .of_o(of_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Independent reference built from the requirements
    function automatic item_t model(input logic [2:0] op, input logic word, input int n,
                                    input logic [15:0] a, input logic ci,
                                    input logic [3:0] fin, input string tag);
        item_t it;
        int w = word ? 16 : 8;
        logic [15:0] mask = word ? 16'hFFFF : 16'h00FF;
        logic [15:0] v = a & mask;
        logic c = ci;
        logic t;
        it.tag = tag;
        it.cycles = n;
        if (n == 0) begin
            it.res = a; it.cf = ci;
            {it.of, it.zf, it.sf, it.pf} = fin;
            it.ftag = "R7";
            return it;
        end
        for (int i = 0; i < n; i++) begin
            case (op)
                3'd4, 3'd6: begin c = v[w-1]; v = (v << 1) & mask; end
                3'd5: begin c = v[0]; v = v >> 1; end
                3'd7: begin c = v[0]; v = (v >> 1) | (16'(v[w-1]) << (w-1)); end
                3'd0: begin c = v[w-1]; v = ((v << 1) | 16'(c)) & mask; end
                3'd1: begin c = v[0]; v = (v >> 1) | (16'(c) << (w-1)); end
                3'd2: begin t = v[w-1]; v = ((v << 1) | 16'(c)) & mask; c = t; end
                default: begin t = v[0]; v = (v >> 1) | (16'(c) << (w-1)); c = t; end
            endcase
        end
        it.res = word ? v : {a[15:8], v[7:0]};
        it.cf  = c;
        it.of  = v[w-1] ^ a[w-1];
        if (op[2]) begin
            it.zf = (v == 0); it.sf = v[w-1]; it.pf = ~^v[7:0];
            it.ftag = "R9";
        end else begin
            {it.zf, it.sf, it.pf} = fin[2:0];
            it.ftag = "R10";
        end
        return it;
    endfunction

    task automatic issue(input logic [2:0] op, input logic word, input logic usec,
                         input logic [7:0] cnt, input logic [15:0] a, input logic ci,
                         input logic [3:0] fin, input string tag, input bit poke = 0);
        int n = usec ? int'(cnt) : 1;
        sb.push_back(model(op, word, n, a, ci, fin, tag));
        @(negedge clk);
        while (busy_o) @(negedge clk);
        op_i = op; word_i = word; use_cnt_i = usec; cnt_i = cnt; opnd_i = a; cf_i = ci;
        {of_i, zf_i, sf_i, pf_i} = fin;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R12: a second request in mid-flight must be dropped
            repeat (2) @(negedge clk);
            op_i = 3'd5; word_i = 1'b1; opnd_i = 16'hFFFF; cnt_i = 8'd1; cf_i = ~ci;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    // Monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy_o) busy_run++;
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R12", "unexpected done", 1, 0);
                end else begin
                    item_t e;
                    e = sb.pop_front();
                    check(res_o == e.res, e.tag, "result", res_o, e.res);
                    check(cf_o == e.cf, e.tag, "carry", cf_o, e.cf);
                    check(of_o == e.of, (e.ftag == "R7") ? "R7" : "R8", "overflow", of_o, e.of);
                    check({zf_o, sf_o, pf_o} == {e.zf, e.sf, e.pf}, e.ftag, "zf/sf/pf",
                          {zf_o, sf_o, pf_o}, {e.zf, e.sf, e.pf});
                    check(busy_run == e.cycles, "R11", "busy cycles", busy_run, e.cycles);
                end
                busy_run = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check({busy_o, done_o, res_o, cf_o, of_o, zf_o, sf_o, pf_o} == '0, "R11",
              "reset outputs", {busy_o, done_o, res_o}, 0);

        issue(3'd4, 1, 0, 8'd0,   16'h8001, 0, 4'b0000, "R1");
        issue(3'd6, 1, 1, 8'd3,   16'h1234, 1, 4'b0000, "R1");
        issue(3'd5, 1, 1, 8'd4,   16'h8F0F, 0, 4'b1111, "R2");
        issue(3'd7, 0, 1, 8'd3,   16'hAB96, 0, 4'b0000, "R2");
        issue(3'd0, 1, 1, 8'd4,   16'h1234, 0, 4'b0101, "R3");
        issue(3'd1, 0, 0, 8'd0,   16'h0081, 0, 4'b0010, "R3");
        issue(3'd2, 1, 0, 8'd0,   16'h8000, 0, 4'b0011, "R4");
        issue(3'd3, 0, 1, 8'd9,   16'h5533, 1, 4'b0110, "R4");
        issue(3'd2, 1, 1, 8'd17,  16'hC0DE, 0, 4'b0000, "R4");
        issue(3'd4, 1, 1, 8'd16,  16'hFFFF, 0, 4'b0000, "R6");
        issue(3'd7, 1, 1, 8'd200, 16'h8000, 0, 4'b0000, "R6");
        issue(3'd0, 1, 1, 8'd0,   16'h4321, 1, 4'b1010, "R7");
        issue(3'd5, 0, 0, 8'd0,   16'h0003, 0, 4'b0000, "R9");
        issue(3'd4, 0, 1, 8'd2,   16'hC3F0, 1, 4'b0000, "R5");
        issue(3'd5, 1, 1, 8'd8,   16'hA5C3, 0, 4'b0000, "R12", 1);

        repeat (300) @(negedge clk);
        check(sb.size() == 0, "R11", "pending results", sb.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule